// File: doc/BRIEF.md
# Page/Block Flash Array Emulator

This block is an on-chip memory that behaves like a page-organised flash array, so that flash-management logic (allocators, wear balancing, bad-page handling) can be exercised against a synthesizable target instead of a real device. Storage is a plain RAM of `BLOCKS x PAGES x PAGE_BYTES` bytes. The smallest readable or programmable unit is one page, and the smallest erasable unit is one block. A program never replaces data: each stored byte becomes the old byte ANDed with the incoming one, so bits can only fall from 1 to 0. Only a block erase sets them back to one.

A command is issued with `cmd_valid`, an opcode, a block and a page. Page data moves over byte-wide streams, one byte per cycle. Programmable busy times (`T_READ`, `T_PROG`, `T_ERASE`) model the slow array. `busy` is high until a single-cycle `done`. At that point `status_viol` tells whether a program tried to raise a 0 bit to 1. Commands that arrive while busy are refused with a `cmd_reject` pulse and are not queued. Each block keeps an erase counter, which a sideband select reads back.

The controller is a single state machine with these states:
- `S_IDLE`
- `S_RD_WAIT` → `S_RD_OUT`
- `S_PG_LOAD` → `S_PG_WAIT`
- `S_ER_WIPE` → `S_ER_WAIT`
- `S_FINISH`

Transitions:
- Accepting a command leaves `S_IDLE` for the first state of its operation.
- Each wait state leaves when its timer expires.
- `S_RD_OUT` and `S_PG_LOAD` leave after the last byte of the page.
- `S_ER_WIPE` leaves after the last byte of the block.
- `S_FINISH` always returns to `S_IDLE`.

Top module: `nand_page_emu`

## Requirements
- R1: After reset the block is idle (`busy`=0, `done`=0, `cmd_reject`=0), every stored byte reads 0xFF and every erase counter is 0.
- R2: A read (opcode 0) streams the addressed page on `rd_data` with `rd_valid` high for `PAGE_BYTES` consecutive cycles, byte 0 first.
- R3: A program (opcode 1) takes `PAGE_BYTES` bytes, one per cycle with `wr_valid` high, byte 0 first. Each stored byte becomes old AND new, so no bit ever changes from 0 to 1.
- R4: `status_viol` is 1 while `done` is high after a program if any incoming byte had a 1 where the stored byte had a 0, and 0 otherwise. It clears when the next command is accepted.
- R5: An erase (opcode 2) sets every byte of every page of the addressed block to 0xFF and leaves other blocks untouched.
- R6: Each accepted erase increments that block's counter by one. `cnt_val` shows the counter of the block chosen by `cnt_sel` in the same cycle.
- R7: Counting cycles after the accepting edge, `done` rises in cycle `T_READ+PAGE_BYTES+1` for a read. For a program with no gaps in `wr_valid` it rises in cycle `PAGE_BYTES+T_PROG+1`. For an erase it rises in cycle `PAGES*PAGE_BYTES+T_ERASE+1`.
- R8: `busy` is high from the cycle after acceptance up to and including the `done` cycle. A `cmd_valid` seen while busy is refused: `cmd_reject` pulses in the next cycle, and the command has no effect on data or counters.
- R9: Opcode 3 is refused even when idle: `cmd_reject` pulses, and `busy` stays low.
- R10: `done` is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 invalid |
| cmd_block | input | BLK_W | Block address |
| cmd_page | input | PG_W | Page address within the block |
| wr_valid | input | 1 | Program data byte valid |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read data byte valid |
| rd_data | output | 8 | Read data byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status_viol | output | 1 | Program attempted a 0-to-1 change |
| cmd_reject | output | 1 | One-cycle refusal pulse |
| cnt_sel | input | BLK_W | Block whose erase count is shown |
| cnt_val | output | CNT_W | Erase count of the selected block |

## Verification
The bench builds the block with four blocks of four eight-byte pages and busy times of 3, 5 and 9 cycles. With these values every page is hit many times by random programs and erases. Repeated programs to the same page without an erase reach both outcomes of the violation flag, and a whole-block wipe stays short enough to repeat often. Having four blocks lets the bench show that an erase or a refused command leaves neighbouring blocks and their counters alone.

// File: rtl/nand_emu_pkg.sv
package nand_emu_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_WAIT,
        S_RD_OUT,
        S_PG_LOAD,
        S_PG_WAIT,
        S_ER_WIPE,
        S_ER_WAIT,
        S_FINISH
    } state_e;

endpackage

// File: rtl/nand_emu_array.sv
module nand_emu_array #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              wipe,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[addr] <= wipe ? 8'hFF : (mem[addr] & wdata);
        end
    end

    // R3: a program write never raises a bit that was 0
    p_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wipe) |=> ((mem[$past(addr)] & ~$past(rdata)) == 8'h00));

    // R5: a wipe write leaves the byte fully erased
    p_wipe_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wipe) |=> (mem[$past(addr)] == 8'hFF));

endmodule

// File: rtl/nand_emu_wear.sv
module nand_emu_wear #(
    parameter int BLOCKS = 4,
    parameter int CNT_W  = 16,
    parameter int BLK_W  = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [BLK_W-1:0] inc_blk,
    input  logic [BLK_W-1:0] sel,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q [BLOCKS];

    assign count = cnt_q[sel];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BLOCKS; i++) cnt_q[i] <= '0;
        end else if (inc) begin
            cnt_q[inc_blk] <= cnt_q[inc_blk] + CNT_W'(1);
        end
    end

    // R6: one erase advances its block's counter by exactly one
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt_q[$past(inc_blk)] == $past(cnt_q[inc_blk]) + CNT_W'(1)));

endmodule

// File: rtl/nand_emu_timer.sv
module nand_emu_timer #(
    parameter int TMR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (run && !expired) cnt_q <= cnt_q - TMR_W'(1);
    end

    // R7: a running count never wraps past zero
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && expired) |=> expired);

endmodule

// File: rtl/nand_page_emu.sv
module nand_page_emu
    import nand_emu_pkg::*;
#(
    parameter int BLOCKS     = 2,
    parameter int PAGES      = 64,
    parameter int PAGE_BYTES = 16,
    parameter int T_READ     = 4,
    parameter int T_PROG     = 40,
    parameter int T_ERASE    = 200,
    parameter int CNT_W      = 16,
    parameter int TMR_W      = 20,
    parameter int BLK_W      = $clog2(BLOCKS),
    parameter int PG_W       = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [BLK_W-1:0] cmd_block,
    input  logic [PG_W-1:0]  cmd_page,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic             done,
    output logic             status_viol,
    output logic             cmd_reject,
    input  logic [BLK_W-1:0] cnt_sel,
    output logic [CNT_W-1:0] cnt_val
);
    localparam int BYTE_W = $clog2(PAGE_BYTES);
    localparam int IDX_W  = PG_W + BYTE_W;
    localparam int ADDR_W = BLK_W + IDX_W;
    localparam int DEPTH  = BLOCKS * PAGES * PAGE_BYTES;

    state_e            state, nxt;
    logic [BLK_W-1:0]  blk_q;
    logic [PG_W-1:0]   page_q;
    logic [IDX_W-1:0]  idx_q;
    logic              viol_q, reject_q;
    logic              accept, page_last, blk_last;
    logic              arr_we, arr_wipe, tmr_load, tmr_run, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_rdata;

    assign accept    = (state == S_IDLE) && cmd_valid && (op_e'(cmd_op) != OP_BAD);
    assign page_last = (idx_q[BYTE_W-1:0] == BYTE_W'(PAGE_BYTES - 1));
    assign blk_last  = (idx_q == {IDX_W{1'b1}});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (accept) begin
                unique case (op_e'(cmd_op))
                    OP_READ:  nxt = S_RD_WAIT;
                    OP_PROG:  nxt = S_PG_LOAD;
                    OP_ERASE: nxt = S_ER_WIPE;
                    OP_BAD:   nxt = S_IDLE;
                endcase
            end
            S_RD_WAIT: if (tmr_done) nxt = S_RD_OUT;
            S_RD_OUT:  if (page_last) nxt = S_FINISH;
            S_PG_LOAD: if (wr_valid && page_last) nxt = S_PG_WAIT;
            S_PG_WAIT: if (tmr_done) nxt = S_FINISH;
            S_ER_WIPE: if (blk_last) nxt = S_ER_WAIT;
            S_ER_WAIT: if (tmr_done) nxt = S_FINISH;
            S_FINISH:  nxt = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q    <= '0;
            page_q   <= '0;
            idx_q    <= '0;
            viol_q   <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= cmd_valid && ((state != S_IDLE) || (op_e'(cmd_op) == OP_BAD));
            if (accept) begin
                blk_q  <= cmd_block;
                page_q <= cmd_page;
                idx_q  <= '0;
                viol_q <= 1'b0;
            end else if (state == S_RD_OUT || state == S_ER_WIPE ||
                         (state == S_PG_LOAD && wr_valid)) begin
                idx_q <= (state == S_ER_WIPE || !page_last) ? idx_q + IDX_W'(1) : '0;
                if (state == S_PG_LOAD && |(wr_data & ~arr_rdata))
                    viol_q <= 1'b1;
            end
        end
    end

    // outputs and array/timer controls
    always_comb begin
        busy        = (state != S_IDLE);
        done        = (state == S_FINISH);
        rd_valid    = (state == S_RD_OUT);
        rd_data     = arr_rdata;
        status_viol = viol_q;
        cmd_reject  = reject_q;
        arr_we      = (state == S_ER_WIPE) || (state == S_PG_LOAD && wr_valid);
        arr_wipe    = (state == S_ER_WIPE);
        arr_addr    = (state == S_ER_WIPE) ? {blk_q, idx_q}
                                           : {blk_q, page_q, idx_q[BYTE_W-1:0]};
        tmr_run     = (state == S_RD_WAIT) || (state == S_PG_WAIT) || (state == S_ER_WAIT);
        tmr_load    = 1'b0;
        tmr_val     = '0;
        if (accept && op_e'(cmd_op) == OP_READ) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_READ - 1);
        end else if (state == S_PG_LOAD && wr_valid && page_last) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_PROG - 1);
        end else if (state == S_ER_WIPE && blk_last) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_ERASE - 1);
        end
    end

    nand_emu_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .addr(arr_addr), .we(arr_we),
        .wipe(arr_wipe), .wdata(wr_data), .rdata(arr_rdata)
    );

    nand_emu_wear #(.BLOCKS(BLOCKS), .CNT_W(CNT_W), .BLK_W(BLK_W)) u_wear (
        .clk(clk), .rst_n(rst_n),
        .inc(accept && op_e'(cmd_op) == OP_ERASE), .inc_blk(cmd_block),
        .sel(cnt_sel), .count(cnt_val)
    );

    nand_emu_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .run(tmr_run), .expired(tmr_done)
    );

    // R8: a request while busy is refused on the next cycle
    p_reject_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> cmd_reject);

    // R8: an accepted command makes the block busy
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: read data only flows while a command is in progress
    p_stream_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    // R9: an invalid opcode seen while idle never starts a command
    p_bad_op_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op == 2'd3) |=> !busy);

endmodule

// File: tb/nand_page_emu_bench.sv
module nand_page_emu_bench;
    localparam int CLK_P = 10;
    localparam int NB = 4, NP = 4, PB = 8;
    localparam int TR = 3, TP = 5, TE = 9;
    localparam int BW = $clog2(NB), PW = $clog2(NP);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, wr_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [BW-1:0] cmd_block = '0, cnt_sel = '0;
    logic [PW-1:0] cmd_page = '0;
    logic [7:0] wr_data = 8'h00, rd_data;
    logic rd_valid, busy, done, status_viol, cmd_reject;
    logic [15:0] cnt_val;

    int checks = 0, errors = 0;
    logic [7:0] model [NB*NP*PB];
    int ecnt [NB];
    logic [7:0] wbuf [PB];
    logic [7:0] rbuf [PB];

    always #(CLK_P/2) clk = ~clk;

    nand_page_emu #(.BLOCKS(NB), .PAGES(NP), .PAGE_BYTES(PB),
                    .T_READ(TR), .T_PROG(TP), .T_ERASE(TE)) u_nand_page_emu (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_block(cmd_block), .cmd_page(cmd_page), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .done(done), .status_viol(status_viol), .cmd_reject(cmd_reject),
        .cnt_sel(cnt_sel), .cnt_val(cnt_val));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_latency(input int op);
        if (op == 0) return TR + PB + 1;
        if (op == 1) return PB + TP + 1;
        return NP * PB + TE + 1;
    endfunction

    function automatic bit exp_viol(input int b, input int p);
        bit v = 0;
        for (int i = 0; i < PB; i++)
            if ((wbuf[i] & ~model[(b*NP+p)*PB+i]) != 8'h00) v = 1;
        return v;
    endfunction

    // op: 0 read, 1 program, 2 erase; inj>0 raises an erase of inj_b at that cycle
    task automatic run_cmd(input int op, input int b, input int p, input int inj, input int inj_b);
        int k = 0, nrd = 0, busy_bad = 0;
        bit v_exp = 0, fin = 0;
        if (op == 1) v_exp = exp_viol(b, p);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_block = BW'(b); cmd_page = PW'(p);
        while (!fin && k < 200) begin
            @(negedge clk);
            k++;
            if (k == 1) cmd_valid = 1'b0;
            if (inj > 0 && k == inj + 1) begin
                chk(cmd_reject == 1'b1, "R8 reject while busy", cmd_reject, 1);
                cmd_valid = 1'b0;
            end
            if (!busy) busy_bad++;
            if (rd_valid && nrd < PB) begin rbuf[nrd] = rd_data; nrd++; end
            if (done) begin
                fin = 1;
                chk(k == exp_latency(op), "R7 done cycle", k, exp_latency(op));
                if (op == 1) chk(status_viol == v_exp, "R4 violation flag", status_viol, v_exp);
            end
            if (op == 1) begin
                wr_valid = (k <= PB);
                wr_data  = (k <= PB) ? wbuf[k-1] : 8'h00;
            end
            if (inj > 0 && k == inj) begin
                cmd_valid = 1'b1; cmd_op = 2'd2; cmd_block = BW'(inj_b);
            end
        end
        wr_valid = 1'b0;
        chk(busy_bad == 0, "R8 busy through done", busy_bad, 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 single done", done, 0);
        if (op == 0) begin
            chk(nrd == PB, "R2 byte count", nrd, PB);
            for (int i = 0; i < PB; i++)
                chk(rbuf[i] == model[(b*NP+p)*PB+i], "R2/R3/R5 read data",
                    rbuf[i], model[(b*NP+p)*PB+i]);
        end else if (op == 1) begin
            for (int i = 0; i < PB; i++)
                model[(b*NP+p)*PB+i] = model[(b*NP+p)*PB+i] & wbuf[i];
        end else begin
            for (int i = 0; i < NP*PB; i++) model[b*NP*PB+i] = 8'hFF;
            ecnt[b]++;
        end
    endtask

    task automatic check_counts();
        for (int b = 0; b < NB; b++) begin
            @(negedge clk);
            cnt_sel = BW'(b);
            #1;
            chk(cnt_val == 16'(ecnt[b]), "R6 erase count", cnt_val, ecnt[b]);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < NB*NP*PB; i++) model[i] = 8'hFF;
        for (int b = 0; b < NB; b++) ecnt[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && done == 1'b0 && cmd_reject == 1'b0, "R1 idle after reset", busy, 0);
        check_counts();
        run_cmd(0, 0, 0, 0, 0);
        run_cmd(0, 3, 3, 0, 0);

        // directed R3/R4: zeros, then ones (violation), then subset (clean)
        for (int i = 0; i < PB; i++) wbuf[i] = 8'h0F;
        run_cmd(1, 1, 2, 0, 0);
        for (int i = 0; i < PB; i++) wbuf[i] = 8'hF0;
        run_cmd(1, 1, 2, 0, 0);
        run_cmd(0, 1, 2, 0, 0);
        for (int i = 0; i < PB; i++) wbuf[i] = 8'h00;
        run_cmd(1, 1, 2, 0, 0);

        // R8: erase request during a program is refused and has no effect
        for (int i = 0; i < PB; i++) wbuf[i] = 8'(8'hA5 ^ i);
        run_cmd(1, 2, 1, 2, 1);
        check_counts();
        run_cmd(0, 1, 2, 0, 0);
        run_cmd(0, 2, 1, 0, 0);

        // R9: opcode 3 refused while idle
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_reject == 1'b1 && busy == 1'b0, "R9 bad opcode", cmd_reject, 1);
        @(negedge clk);
        chk(cmd_reject == 1'b0 && busy == 1'b0, "R9 reject pulse ends", cmd_reject, 0);

        // R5: erase one block, neighbour keeps its data
        run_cmd(2, 1, 0, 0, 0);
        run_cmd(0, 1, 2, 0, 0);
        run_cmd(0, 2, 1, 0, 0);
        check_counts();

        // random mix
        for (int n = 0; n < 60; n++) begin
            int op, b, p;
            op = $urandom % 5;
            op = (op >= 3) ? 1 : op;
            b = $urandom % NB;
            p = $urandom % NP;
            if (op == 1)
                for (int i = 0; i < PB; i++)
                    wbuf[i] = 8'($urandom) | (($urandom % 2) ? 8'h00 : 8'($urandom));
            run_cmd(op, b, p, 0, 0);
            if (op == 1) run_cmd(0, b, p, 0, 0);
        end
        check_counts();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule